// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a two-wire PHY management port. Software loads one 32-bit command word. The word carries, from the top down: two start bits, a two-bit operation, a five-bit PHY address, a five-bit register address, a two-bit turnaround code and sixteen data bits. The block then sends a Clause 22 frame on the MDC clock and the MDIO data line. It drives the line through an output-enable, so that an external open-drain or tri-state pad can release it.

Every frame begins with 32 preamble ones. The 32 bits of the command word follow, most significant bit first. For a read, the block releases the data line from the first turnaround bit to the end of the frame. It samples the sixteen data bits on rising MDC edges and shifts them into the low half of the same command word, so software reads the result from the register it wrote. MDC is the system clock divided by 8, 16, 32 or 64. A port-enable input gates the whole port. An idle flag and a sticky frame-done flag report progress, and the live data-line input level is also brought out.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: The command word layout is data [15:0], turnaround [17:16], register address [22:18], PHY address [27:23], operation [29:28] and start [31:30]. A frame is 64 bit periods: 32 ones, then command bits 31 down to 0. Each bit is driven while MDC is low.
- R2: When the operation field is 2'b10 (read), mdio_oe is low from frame bit 46 (the first turnaround bit) to the end of the frame. The value on mdio_in just before each of the MDC rises in bits 48 to 63 is shifted into cmd_word[15:0], most significant bit first. cmd_word[31:16] keeps its value. Any other operation code, including 2'b01 (write), drives all 64 bits.
- R3: clk_sel values 0, 1, 2 and 3 make each MDC period 8, 16, 32 or 64 system clocks, with MDC high for the second half of the period. clk_sel is taken when a command is accepted.
- R4: While port_en is low, mdc and mdio_oe stay low and a command write is ignored. If port_en drops during a frame, the frame is abandoned: idle returns to 1 on the next clock and done_irq is not set.
- R5: idle goes low in the cycle after a command is accepted. It stays low for exactly 64 MDC periods, until the last data bit's period has ended.
- R6: A command write while a frame is running is ignored. The running frame and cmd_word are not changed by it.
- R7: done_irq is set when a frame completes and stays set until irq_clr is pulsed. If completion and irq_clr fall in the same clock, completion wins.
- R8: mdio_level always follows mdio_in.
- R9: After reset, cmd_word is 0, idle is 1 and done_irq, mdc, mdio_out and mdio_oe are 0.
- R10: mdio_out does not change while MDC stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Management port enable |
| clk_sel | input | 2 | MDC divider select (8/16/32/64) |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to load |
| irq_clr | input | 1 | Clears the frame-done flag |
| mdio_in | input | 1 | Data line input from the pad |
| cmd_word | output | 32 | Command word, with read data in bits 15:0 after a read |
| idle | output | 1 | 1 when no frame is in progress |
| done_irq | output | 1 | Sticky frame-done flag |
| mdio_level | output | 1 | Live level of mdio_in |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
The hardest state to reach from the ports is a read whose returned bits land in the right order. That requires a responder that follows MDC and puts each data bit on the line before the rise the block samples. The bench therefore contains a small PHY responder. It counts MDC rises while a frame runs, and after rise k it presents the bit meant for rise k+1. The same counter records mdio_out and mdio_oe at every rise, so the driven frame and the released window are compared bit by bit. The abort and busy-write cases are reached by waiting a fixed number of cycles into a running frame before changing port_en or pulsing cmd_wr.

// File: rtl/mdio_pkg.sv
// Shared constants for the management frame controller.
// Assumes a Clause 22 frame: preamble followed by one 32-bit command word.
package mdio_pkg;
    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = PRE_LEN + CMD_W;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    // Frame position of command bit b is PRE_LEN + (CMD_W-1-b).
    localparam int TA_FIRST   = PRE_LEN + CMD_W - 1 - 17;
    localparam int DATA_FIRST = PRE_LEN + CMD_W - DATA_W;
    localparam int OP_LSB     = 28;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
// MDC divider: counts a period of 2*half system clocks, where half is
// BASE_HALF << sel. MDC is low in the first half and high in the second.
// Assumes sel is latched on restart and stays fixed for the whole frame.
module mdio_clk_div #(
    parameter int BASE_HALF = 4,
    parameter int SEL_W     = 2,
    localparam int MAX_PER  = 2 * BASE_HALF << ((1 << SEL_W) - 1),
    localparam int CNT_W    = $clog2(MAX_PER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc_hi,
    output logic             rise_evt,
    output logic             period_end
);
    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] half_w;

    assign half_w     = CNT_W'(BASE_HALF) << sel_q;
    assign mdc_hi     = (cnt >= half_w);
    assign rise_evt   = run && (cnt == half_w - 1'b1);
    assign period_end = run && (cnt == (half_w << 1) - 1'b1);

    // Period counter: cleared on restart, advanced while the frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sel_q <= '0;
        end else if (restart) begin
            cnt   <= '0;
            sel_q <= sel;
        end else if (run) begin
            cnt <= period_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_bit_seq.sv
// Frame bit sequencer: tracks which of the FRAME_LEN bit periods is current
// and whether a frame is in progress. Assumes step pulses once per MDC period.
module mdio_bit_seq #(
    parameter int FRAME_LEN = 64,
    localparam int IDX_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             step,
    output logic             busy,
    output logic [IDX_W-1:0] bit_idx,
    output logic             finish
);
    logic last;

    assign last   = (bit_idx == IDX_W'(FRAME_LEN - 1));
    assign finish = busy && step && last;

    // Busy flag and bit index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (busy && step) begin
            if (last) busy <= 1'b0;
            else      bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
// MDIO management frame controller (top). Loads a command word, sends a
// 32-one preamble and the word MSB first, releases the line for reads and
// captures the returned data into the word's low half.
// Assumes an external pad combines mdio_out/mdio_oe into the shared line.
module mdio_frame_ctrl #(
    parameter int BASE_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic [1:0]  clk_sel,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    input  logic        irq_clr,
    input  logic        mdio_in,
    output logic [31:0] cmd_word,
    output logic        idle,
    output logic        done_irq,
    output logic        mdio_level,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe
);
    import mdio_pkg::*;

    logic             busy, accept, abort, run;
    logic             mdc_hi, rise_evt, period_end, finish;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] word_pos;
    logic [CMD_W-1:0] cmd_q;
    logic             is_read, capture, drive_phase, tx_bit;

    assign accept = cmd_wr && port_en && !busy;
    assign abort  = busy && !port_en;
    assign run    = busy && port_en;

    mdio_clk_div #(.BASE_HALF(BASE_HALF), .SEL_W(2)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .run        (run),
        .sel        (clk_sel),
        .mdc_hi     (mdc_hi),
        .rise_evt   (rise_evt),
        .period_end (period_end)
    );

    mdio_bit_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .abort   (abort),
        .step    (period_end),
        .busy    (busy),
        .bit_idx (bit_idx),
        .finish  (finish)
    );

    assign is_read     = (cmd_q[OP_LSB+1:OP_LSB] == OP_READ);
    assign capture     = busy && rise_evt && is_read && (bit_idx >= IDX_W'(DATA_FIRST));
    assign drive_phase = !(is_read && (bit_idx >= IDX_W'(TA_FIRST)));
    assign word_pos    = IDX_W'(FRAME_LEN - 1) - bit_idx;
    assign tx_bit      = (bit_idx < IDX_W'(PRE_LEN)) ? 1'b1 : cmd_q[word_pos[$clog2(CMD_W)-1:0]];

    // Command word: loaded on accept, low half shifts in read data.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (accept)  cmd_q <= cmd_wdata;
        else if (capture) cmd_q <= {cmd_q[CMD_W-1:DATA_W], cmd_q[DATA_W-2:0], mdio_in};
    end

    // Sticky frame-done flag; completion wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_irq <= 1'b0;
        else if (finish)  done_irq <= 1'b1;
        else if (irq_clr) done_irq <= 1'b0;
    end

    assign cmd_word   = cmd_q;
    assign idle       = !busy;
    assign mdio_level = mdio_in;
    assign mdc        = run && mdc_hi;
    assign mdio_oe    = run && drive_phase;
    assign mdio_out   = mdio_oe && tx_bit;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
// Property checker for mdio_frame_ctrl, attached by bind below.
// Assumes the same port names as the top module.
module mdio_frame_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_en,
    input logic [31:0] cmd_word,
    input logic        idle,
    input logic        done_irq,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);
    p_drop_enable_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> idle);

    p_oe_needs_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !idle);

    p_word_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(cmd_word[31:16]));

    p_done_on_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle) && $past(port_en)) |-> done_irq);

    p_out_steady_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (.*);

// File: tb/mdio_frame_ctrl_tb.sv
module mdio_frame_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        irq_clr = 1'b0;
    logic        mdio_in;
    logic [31:0] cmd_word;
    logic        idle, done_irq, mdio_level, mdc, mdio_out, mdio_oe;

    logic        phy_en = 1'b1;
    logic        force_lvl = 1'b0;
    logic        phy_bit = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] fbits, obits;
    logic        mdc_d = 1'b0;
    int          ridx = 0;
    int          errs = 0;
    int          checks = 0;

    always #4 clk = ~clk;  // 125 MHz

    assign mdio_in = phy_en ? phy_bit : force_lvl;

    mdio_frame_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .clk_sel(clk_sel),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .irq_clr(irq_clr),
        .mdio_in(mdio_in), .cmd_word(cmd_word), .idle(idle),
        .done_irq(done_irq), .mdio_level(mdio_level), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    // PHY responder and frame recorder, one clock after each MDC rise.
    always @(posedge clk) begin
        mdc_d <= mdc;
        if (idle) begin
            ridx <= 0;
        end else if (mdc && !mdc_d) begin
            if (ridx < 64) begin
                fbits[63-ridx] <= mdio_out;
                obits[63-ridx] <= mdio_oe;
            end
            if (ridx + 1 >= 48 && ridx + 1 < 64)
                phy_bit <= phy_data[62-ridx];
            ridx <= ridx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sends one command and counts the cycles idle stays low.
    task automatic run_frame(input logic [1:0] sel, input logic [31:0] cmd, output int n);
        @(negedge clk);
        clk_sel = sel; cmd_wdata = cmd; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        n = 0;
        while (idle == 1'b0 && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] cmd;
        logic [15:0] phy;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, {2'b01, 2'b01, 5'd3,  5'd1,  2'b10, 16'hA5C3}, 16'h0000},
        '{2'd1, {2'b01, 2'b10, 5'd31, 5'd0,  2'b10, 16'h0000}, 16'h8001},
        '{2'd2, {2'b01, 2'b01, 5'd0,  5'd31, 2'b10, 16'hFFFF}, 16'h0000},
        '{2'd3, {2'b01, 2'b10, 5'd17, 5'd9,  2'b10, 16'h1234}, 16'h6C3E}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int n;
        logic [63:0] exp_f, exp_o;
        logic        rd;
        logic [31:0] exp_w;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(cmd_word == 0 && idle && !done_irq && !mdc && !mdio_out && !mdio_oe,
              "R9 reset", {cmd_word, 26'd0, idle, done_irq, mdc, mdio_out, mdio_oe, 1'b0},
              {32'd0, 26'd0, 1'b1, 5'd0});

        // R4: command ignored while port disabled
        run_frame(2'd0, 32'h5555_1234, n);
        check(n == 0 && cmd_word == 0, "R4 disabled write", 64'(n), 64'd0);

        port_en = 1'b1;
        // Table walk: R1 R2 R3 R5 R7
        for (int v = 0; v < 4; v++) begin
            phy_data = VECS[v].phy;
            run_frame(VECS[v].sel, VECS[v].cmd, n);
            rd    = (VECS[v].cmd[29:28] == 2'b10);
            exp_w = rd ? {VECS[v].cmd[31:16], VECS[v].phy} : VECS[v].cmd;
            exp_f = {32'hFFFF_FFFF, VECS[v].cmd};
            exp_o = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
            check(n == 64 * (8 << VECS[v].sel), "R3/R5 frame length", 64'(n), 64'(64 * (8 << VECS[v].sel)));
            check(obits == exp_o, "R2 output enable window", obits, exp_o);
            check(((fbits ^ exp_f) & exp_o) == 0, "R1 frame bits", fbits & exp_o, exp_f & exp_o);
            check(cmd_word == exp_w, "R2 command word after frame", 64'(cmd_word), 64'(exp_w));
            check(done_irq == 1'b1, "R7 done set", 64'(done_irq), 64'd1);
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            check(done_irq == 1'b0, "R7 done cleared", 64'(done_irq), 64'd0);
        end

        // R6: write during a running frame is ignored
        @(negedge clk);
        cmd_wdata = {2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h0F0F};
        clk_sel = 2'd0; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (100) @(negedge clk);
        cmd_wdata = 32'h9999_9999; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        n = 0;
        while (!idle && n < 10000) begin n++; @(negedge clk); end
        check(cmd_word == {2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h0F0F}, "R6 word kept",
              64'(cmd_word), 64'({2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h0F0F}));
        check(fbits == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h0F0F}, "R6 frame kept",
              fbits, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'h0F0F});
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;

        // R4: abort by dropping the port enable mid-frame
        cmd_wdata = 32'h5A5A_5A5A; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (50) @(negedge clk);
        port_en = 1'b0;
        #1;
        check(!mdc && !mdio_oe, "R4 quiet when disabled", {62'd0, mdc, mdio_oe}, 64'd0);
        @(negedge clk);
        check(idle == 1'b1, "R4 abort idle", 64'(idle), 64'd1);
        repeat (600) @(negedge clk);
        check(done_irq == 1'b0, "R4 no done on abort", 64'(done_irq), 64'd0);

        // R8: live input level
        phy_en = 1'b0;
        force_lvl = 1'b1;
        #1;
        check(mdio_level == 1'b1, "R8 level high", 64'(mdio_level), 64'd1);
        force_lvl = 1'b0;
        #1;
        check(mdio_level == 1'b0, "R8 level low", 64'(mdio_level), 64'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule